// File: doc/BRIEF.md
# Dual-Rate Raster Slot Scheduler

This block works out, for every slot of a raster line, which memory client owns that slot. Its counter runs one step per clock and covers the whole line. A fixed set of early slots goes to DRAM refresh, disk, audio and sprite transfers. A later window goes to bitplane fetches, and the layout of that window depends on the display resolution and on how many bitplanes are enabled. Every other slot is reported as open, so CPU, copper or blitter traffic can use it.

Two conditions must both hold to select the clock-doubled rate: an extension enable input and a separate rate-select input. At that rate the line is twice as long, so twice as many slots are available. The fixed channels stay in the same slots as at the normal rate. The bitplane window moves. In doubled low resolution, every 8-slot fetch block is followed by 8 idle slots, because the pixel pipeline uses the data at half speed. A one-slot strobe marks the last slot of each fetch block. The pixel pipeline uses this strobe to know that a full set of plane words has arrived.

The mode inputs are captured only when a line begins. A line begins on an external line-start pulse, or when the counter wraps by itself. At the normal rate, lines alternate between 227 and 228 slots, which gives an average of 227.5.

Top module: `raster_slot_sched`

## Requirements
- R1: After reset, slot reads 0, grant reads 0 (open) and fetch_done is low.
- R2: A line_start sampled high sets slot to 0 at the next clock edge. Otherwise slot goes up by one at each edge until the end of the line.
- R3: At the normal rate, line parity toggles at every new line, and the first line after reset has even parity. An even line runs from slot 0 to 226 and an odd line from slot 0 to 227, after which the counter wraps to 0 without a line_start.
- R4: The doubled rate is in force only when ext_en and dbl_sel are both high at the start of a line. A doubled line runs from slot 0 to 454. If only one of the two is high, the line behaves exactly as at the normal rate.
- R5: At both rates, the fixed channels own these slots: refresh (grant 1) at 1, 3, 5 and 7; disk (grant 2) at 9, 11 and 13; audio (grant 3) at 15, 17, 19 and 21; sprites (grant 4) at every odd slot from 23 to 53.
- R6: In normal low resolution, the bitplane window starts at slot 0x38. It is made of 20 back-to-back blocks of 8 slots, and at most 6 planes are fetched.
- R7: In normal high resolution, the window starts at slot 0x3C. It is made of 40 back-to-back blocks of 4 slots, and at most 4 planes are fetched.
- R8: In doubled low resolution, the window starts at slot 0x70. It is made of 20 periods of 16 slots: 8 fetch slots followed by 8 idle slots (grant 6). At most 8 planes are fetched.
- R9: In doubled high resolution, the window starts at slot 0x78. It is made of 40 back-to-back blocks of 8 slots with no idle gap, and at most 8 planes are fetched.
- R10: Inside a block, the first min(plane_cnt, limit) slots are bitplane fetches (grant 5) and the remaining slots of the block are free (grant 6). A plane count above the mode's limit is clamped to that limit.
- R11: fetch_done is high during the last slot of each block and only then. With a plane count of 0 there is no window at all: those slots are open (grant 0) and no strobe occurs.
- R12: If hires, plane_cnt, ext_en or dbl_sel change in the middle of a line, the schedule of that line does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous reset, active high |
| line_start | input | 1 | Restarts the line at the next edge |
| ext_en | input | 1 | Extension enable, one of the two doubled-rate conditions |
| dbl_sel | input | 1 | Doubled-rate select |
| hires | input | 1 | High resolution when 1 |
| plane_cnt | input | 4 | Number of bitplanes to fetch |
| slot | output | 9 | Current slot number |
| grant | output | 3 | Owner of the current slot (0 open, 1 refresh, 2 disk, 3 audio, 4 sprite, 5 bitplane, 6 free) |
| fetch_done | output | 1 | High during the last slot of a fetch block |

## Verification
The assertions assume line_start is a synchronous level sampled at the clock edge. They also assume the mode inputs may change at any time, because the design promises to ignore them until the next line begins. The properties on the counter assume the mode held for the line is the one that sets its length. For that reason the stimulus changes the mode inputs only while line_start is high, except in the one test that changes them on purpose in the middle of a line to exercise R12. The sweep covers every combination of the two rate bits, both resolutions and plane counts 0 through 9, so it includes counts above every mode's limit.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int PLANE_W = 4;
  localparam int GRANT_W = 3;

  typedef enum logic [GRANT_W-1:0] {
    GR_OPEN    = 3'd0,
    GR_REFRESH = 3'd1,
    GR_DISK    = 3'd2,
    GR_AUDIO   = 3'd3,
    GR_SPRITE  = 3'd4,
    GR_PLANE   = 3'd5,
    GR_FREE    = 3'd6
  } grant_e;

  typedef struct packed {
    logic               dbl;
    logic               hires;
    logic [PLANE_W-1:0] planes;
  } mode_t;
endpackage

// File: rtl/rss_line_timer.sv
module rss_line_timer
  import rss_pkg::*;
#(
  parameter int NORM_SLOTS = 227,
  parameter int SLOT_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  mode_t             mode_in,
  output logic [SLOT_W-1:0] slot_q,
  output logic [SLOT_W-1:0] slot_nx,
  output mode_t             mode_nx
);
  localparam int DBL_LAST = 2 * NORM_SLOTS;

  mode_t             mode_q;
  logic              odd_q, odd_nx;
  logic [SLOT_W-1:0] last_slot;
  logic              new_line;

  always_comb begin
    if (mode_q.dbl)  last_slot = SLOT_W'(DBL_LAST);
    else if (odd_q)  last_slot = SLOT_W'(NORM_SLOTS);
    else             last_slot = SLOT_W'(NORM_SLOTS - 1);
  end

  assign new_line = line_start || (slot_q == last_slot);

  always_comb begin
    if (new_line) begin
      slot_nx = '0;
      odd_nx  = ~odd_q;
      mode_nx = mode_in;
    end else begin
      slot_nx = slot_q + 1'b1;
      odd_nx  = odd_q;
      mode_nx = mode_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      odd_q  <= 1'b0;
      mode_q <= '0;
    end else begin
      slot_q <= slot_nx;
      odd_q  <= odd_nx;
      mode_q <= mode_nx;
    end
  end

  // R2: restart lands on slot zero
  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    line_start |=> (slot_q == '0));

  // R2: plain advance by one
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!line_start && slot_q != last_slot) |=> (slot_q == SLOT_W'($past(slot_q) + 1'b1)));

  // R3: counter never passes the end of its line
  p_range_r3: assert property (@(posedge clk) disable iff (rst)
    slot_q <= last_slot);

  // R4: a normal-rate line stays below the doubled range
  p_norm_len_r4: assert property (@(posedge clk) disable iff (rst)
    !mode_q.dbl |-> (slot_q <= SLOT_W'(NORM_SLOTS)));

  // R12: captured mode only changes at a line boundary
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!line_start && slot_q != last_slot) |=> $stable(mode_q));
endmodule

// File: rtl/rss_fixed_dec.sv
module rss_fixed_dec
  import rss_pkg::*;
#(
  parameter int SLOT_W    = 9,
  parameter int REF_FIRST = 1,
  parameter int REF_CNT   = 4,
  parameter int DSK_FIRST = 9,
  parameter int DSK_CNT   = 3,
  parameter int AUD_FIRST = 15,
  parameter int AUD_CNT   = 4,
  parameter int SPR_FIRST = 23,
  parameter int SPR_CNT   = 16
) (
  input  logic [SLOT_W-1:0] slot,
  output logic              hit,
  output grant_e            code
);
  localparam int NCH = 4;
  localparam int FIRSTS [NCH] = '{REF_FIRST, DSK_FIRST, AUD_FIRST, SPR_FIRST};
  localparam int COUNTS [NCH] = '{REF_CNT, DSK_CNT, AUD_CNT, SPR_CNT};

  logic [NCH-1:0] ch_hit;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int LO = FIRSTS[g];
    localparam int HI = FIRSTS[g] + 2 * COUNTS[g];
    always_comb begin
      ch_hit[g] = (int'(slot) >= LO) && (int'(slot) < HI) &&
                  (((int'(slot) - LO) % 2) == 0);
    end
  end

  always_comb begin
    hit  = |ch_hit;
    code = GR_OPEN;
    if (ch_hit[0])      code = GR_REFRESH;
    else if (ch_hit[1]) code = GR_DISK;
    else if (ch_hit[2]) code = GR_AUDIO;
    else if (ch_hit[3]) code = GR_SPRITE;
  end
endmodule

// File: rtl/rss_fetch_dec.sv
module rss_fetch_dec
  import rss_pkg::*;
#(
  parameter int SLOT_W      = 9,
  parameter int LO_START    = 'h38,
  parameter int HI_START    = 'h3C,
  parameter int LO_LEN      = 8,
  parameter int HI_LEN      = 4,
  parameter int LO_BLOCKS   = 20,
  parameter int HI_BLOCKS   = 40,
  parameter int NORM_LO_MAX = 6,
  parameter int NORM_HI_MAX = 4,
  parameter int DBL_MAX     = 8
) (
  input  logic [SLOT_W-1:0] slot,
  input  mode_t             mode,
  output logic              hit,
  output logic              last,
  output grant_e            code
);
  localparam int W1    = SLOT_W + 1;
  localparam int OFF_W = $clog2(2 * LO_LEN) + 1;

  logic [W1-1:0]      start, win, rel;
  logic [OFF_W-1:0]   len_m1, per_mask, off, pe_ext;
  logic [PLANE_W-1:0] maxp, pe;
  logic               in_range;

  always_comb begin
    unique case ({mode.dbl, mode.hires})
      2'b00: begin
        start = W1'(LO_START);       len_m1 = OFF_W'(LO_LEN - 1);
        per_mask = OFF_W'(LO_LEN - 1); win = W1'(LO_LEN * LO_BLOCKS);
        maxp = PLANE_W'(NORM_LO_MAX);
      end
      2'b01: begin
        start = W1'(HI_START);       len_m1 = OFF_W'(HI_LEN - 1);
        per_mask = OFF_W'(HI_LEN - 1); win = W1'(HI_LEN * HI_BLOCKS);
        maxp = PLANE_W'(NORM_HI_MAX);
      end
      2'b10: begin
        start = W1'(2 * LO_START);   len_m1 = OFF_W'(LO_LEN - 1);
        per_mask = OFF_W'(2 * LO_LEN - 1); win = W1'(2 * LO_LEN * LO_BLOCKS);
        maxp = PLANE_W'(DBL_MAX);
      end
      default: begin
        start = W1'(2 * HI_START);   len_m1 = OFF_W'(LO_LEN - 1);
        per_mask = OFF_W'(LO_LEN - 1); win = W1'(LO_LEN * HI_BLOCKS);
        maxp = PLANE_W'(DBL_MAX);
      end
    endcase
  end

  always_comb begin
    rel      = {1'b0, slot} - start;
    in_range = ({1'b0, slot} >= start) && (rel < win);
    off      = rel[OFF_W-1:0] & per_mask;
    pe       = (mode.planes > maxp) ? maxp : mode.planes;
    pe_ext   = OFF_W'(pe);
    hit      = in_range && (mode.planes != '0);
    last     = hit && (off == len_m1);
    code     = GR_OPEN;
    if (hit) code = ((off <= len_m1) && (off < pe_ext)) ? GR_PLANE : GR_FREE;
  end
endmodule

// File: rtl/raster_slot_sched.sv
module raster_slot_sched
  import rss_pkg::*;
#(
  parameter int NORM_SLOTS = 227,
  parameter int LO_START   = 'h38,
  parameter int HI_START   = 'h3C,
  parameter int REF_FIRST  = 1,
  localparam int SLOT_W    = $clog2(2 * NORM_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_start,
  input  logic               ext_en,
  input  logic               dbl_sel,
  input  logic               hires,
  input  logic [PLANE_W-1:0] plane_cnt,
  output logic [SLOT_W-1:0]  slot,
  output logic [GRANT_W-1:0] grant,
  output logic               fetch_done
);
  mode_t             mode_in, mode_nx;
  logic [SLOT_W-1:0] slot_nx;
  logic              fix_hit, fb_hit, fb_last;
  grant_e            fix_code, fb_code, code_nx, grant_q;
  logic              done_q;

  always_comb begin
    mode_in.dbl    = ext_en & dbl_sel;
    mode_in.hires  = hires;
    mode_in.planes = plane_cnt;
  end

  rss_line_timer #(.NORM_SLOTS(NORM_SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk(clk), .rst(rst), .line_start(line_start), .mode_in(mode_in),
    .slot_q(slot), .slot_nx(slot_nx), .mode_nx(mode_nx)
  );

  rss_fixed_dec #(.SLOT_W(SLOT_W), .REF_FIRST(REF_FIRST)) u_fixed (
    .slot(slot_nx), .hit(fix_hit), .code(fix_code)
  );

  rss_fetch_dec #(.SLOT_W(SLOT_W), .LO_START(LO_START), .HI_START(HI_START)) u_fetch (
    .slot(slot_nx), .mode(mode_nx), .hit(fb_hit), .last(fb_last), .code(fb_code)
  );

  always_comb begin
    if (fix_hit)     code_nx = fix_code;
    else if (fb_hit) code_nx = fb_code;
    else             code_nx = GR_OPEN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= GR_OPEN;
      done_q  <= 1'b0;
    end else begin
      grant_q <= code_nx;
      done_q  <= fb_last && !fix_hit;
    end
  end

  assign grant      = grant_q;
  assign fetch_done = done_q;

  // R11: strobe only inside a fetch block
  p_done_fetch_r11: assert property (@(posedge clk) disable iff (rst)
    fetch_done |-> (grant == GR_PLANE || grant == GR_FREE));

  // R11: strobe lasts one slot
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    fetch_done |=> !fetch_done);

  // R6: no bitplane grant before the earliest window start
  p_plane_after_start_r6: assert property (@(posedge clk) disable iff (rst)
    (grant == GR_PLANE) |-> (slot >= SLOT_W'(LO_START)));

  // R5: refresh slot is fixed at both rates
  p_refresh_r5: assert property (@(posedge clk) disable iff (rst)
    (slot == SLOT_W'(REF_FIRST)) |-> (grant == GR_REFRESH));
endmodule

// File: tb/sim_raster_slot_sched.sv
`timescale 1ns/1ps
module sim_raster_slot_sched;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       line_start = 1'b0;
  logic       ext_en = 1'b0, dbl_sel = 1'b0, hires = 1'b0;
  logic [3:0] plane_cnt = '0;
  logic [8:0] slot;
  logic [2:0] grant;
  logic       fetch_done;

  int  n_chk = 0, n_fail = 0;
  bit  par = 1'b0;
  bit  lat_d, lat_h;
  int  lat_p;

  always #10 clk = ~clk;

  raster_slot_sched u0 (
    .clk(clk), .rst(rst), .line_start(line_start), .ext_en(ext_en),
    .dbl_sel(dbl_sel), .hires(hires), .plane_cnt(plane_cnt),
    .slot(slot), .grant(grant), .fetch_done(fetch_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int line_len(input bit d, input bit p);
    return d ? 455 : (p ? 228 : 227);
  endfunction

  task automatic model(input int s, input bit d, input bit h, input int p,
                       output int g, output int dn, output string tag);
    int st, ln, per, blk, mx, pe, off;
    g = 0; dn = 0; tag = "R11";
    if (s % 2 == 1 && s <= 53) begin
      tag = "R5";
      if (s <= 7) g = 1; else if (s <= 13) g = 2; else if (s <= 21) g = 3; else g = 4;
      return;
    end
    if (!d && !h)     begin st = 'h38; ln = 8; per = 8;  blk = 20; mx = 6; tag = "R6"; end
    else if (!d && h) begin st = 'h3C; ln = 4; per = 4;  blk = 40; mx = 4; tag = "R7"; end
    else if (d && !h) begin st = 'h70; ln = 8; per = 16; blk = 20; mx = 8; tag = "R8"; end
    else              begin st = 'h78; ln = 8; per = 8;  blk = 40; mx = 8; tag = "R9"; end
    pe = (p > mx) ? mx : p;
    if (p == 0) tag = "R11";
    if (pe > 0 && s >= st && s < st + per * blk) begin
      off = (s - st) % per;
      if (off < ln) begin
        g  = (off < pe) ? 5 : 6;
        dn = (off == ln - 1) ? 1 : 0;
        if (g == 6) tag = "R10";
      end else g = 6;
    end
  endtask

  task automatic check_slot(input int n, input string slot_tag, input string over);
    int g, dn;
    string tag;
    model(n, lat_d, lat_h, lat_p, g, dn, tag);
    if (over != "") tag = over;
    check(slot == 9'(n), slot_tag, int'(slot), n);
    check(grant == 3'(g), tag, int'(grant), g);
    check(fetch_done == dn[0], "R11", int'(fetch_done), dn);
  endtask

  task automatic start_line(input bit e, input bit s, input bit h, input int p);
    ext_en = e; dbl_sel = s; hires = h; plane_cnt = 4'(p);
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    par   = ~par;
    lat_d = e & s; lat_h = h; lat_p = p;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state seen before any new line; counter has advanced one step
    check(slot == 9'd1, "R1", int'(slot), 1);
    check(fetch_done == 1'b0, "R1", int'(fetch_done), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(slot == 9'd0, "R1", int'(slot), 0);
    check(grant == 3'd0, "R1", int'(grant), 0);
    check(fetch_done == 1'b0, "R1", int'(fetch_done), 0);
    par = 1'b0;

    // Sweep every rate pair, resolution and plane count 0..9
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++)
        for (int h = 0; h < 2; h++)
          for (int p = 0; p < 10; p++) begin
            int len;
            start_line(e[0], s[0], h[0], p);
            len = line_len(lat_d, par);
            for (int n = 0; n < len; n++) begin
              check_slot(n, (e == 1 && s == 1) ? "R4" : "R2", "");
              if (n < len - 1) @(negedge clk);
            end
          end

    // R3: free-running wrap with alternating lengths
    start_line(1'b1, 1'b0, 1'b0, 3);
    for (int l = 0; l < 3; l++) begin
      int len;
      len = line_len(1'b0, par);
      for (int n = 0; n < len; n++) begin
        check_slot(n, "R3", "");
        @(negedge clk);
      end
      par = ~par;
      check(slot == 9'd0, "R3", int'(slot), 0);
    end

    // R12: change every mode input mid-line, schedule must not move
    start_line(1'b1, 1'b1, 1'b0, 8);
    for (int n = 0; n < 'hA0; n++) begin
      if (n == 'h20) begin
        ext_en = 1'b0; hires = 1'b1; plane_cnt = 4'd2;
      end
      check_slot(n, "R12", (n > 'h20) ? "R12" : "");
      @(negedge clk);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule